// File: doc/BRIEF.md
# Dead-Zone Width Scan Sequencer

This block drives the phase-select code that sets the dead-zone width of a variable dead-zone bang-bang phase detector. It runs on a slow clock derived from the recovered clock. It walks a staircase of N discrete width codes, starting at 0 and ending at N-1. Each code is held for the same number of slow-clock cycles, and after the last code the staircase starts again from the first. Averaged over one scan, the detector then has a multi-level gain. The gain grows with N, and N is also presented downstream as a thermometer code.

A single enable switches the variable-width path on or off. When it is off, the code stays at zero and the valid flag is low, so only the plain bang-bang path contributes. The step count and the hold length are sampled only at the start of a scan period, so a scan that is in flight is never cut short or stretched. Two one-cycle strobes go to the jitter-histogram counters downstream: one marks each new step and one marks each new period.

Top module: `dzw_scan_seq`

## Requirements
- R1: While reset is held, and on the first output after reset with the enable low, `phase_code_o`, `therm_o`, `code_valid_o`, `step_stb_o` and `period_stb_o` are all zero.
- R2: At the first clock edge at which `scan_en` is seen high after being low (or after reset), the outputs become: `code_valid_o`=1, `phase_code_o`=0, and both `step_stb_o` and `period_stb_o` high.
- R3: While enabled, `phase_code_o` takes the values 0, 1, …, N-1 in ascending order. It holds each value for exactly H consecutive cycles and then returns to 0, repeating for as long as the enable stays high.
- R4: `step_stb_o` is high for exactly one cycle in the first cycle of every step, and low in every other cycle.
- R5: `period_stb_o` is high for exactly one cycle whenever the code starts a new period at 0, and never high without `step_stb_o`.
- R6: One edge after `scan_en` is seen low, the code, the thermometer and both strobes are zero and `code_valid_o` is low. A later enable restarts the scan at code 0, as in R2.
- R7: While `code_valid_o` is high, `therm_o` has its N least-significant bits set and all other bits clear. While it is low, `therm_o` is zero.
- R8: The effective N is `step_cnt_i` clamped to the range 4 to 8. Values below 4 act as 4 and values above 8 act as 8.
- R9: The effective hold length H is `hold_len_i`, except that a value of 0 acts as 1.
- R10: New values on `step_cnt_i` or `hold_len_i` take effect only at the start of a period: either the R2 start or the wrap back to code 0. A change in mid-period leaves the current staircase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | High runs the width scan; low selects plain bang-bang operation |
| step_cnt_i | input | 4 | Requested number of widths N (clamped 4..8) |
| hold_len_i | input | 8 | Slow-clock cycles per width H (0 acts as 1) |
| phase_code_o | output | 3 | Dead-zone phase-select code |
| therm_o | output | 8 | Thermometer form of the active N |
| code_valid_o | output | 1 | Variable-width path active |
| step_stb_o | output | 1 | One-cycle pulse at the start of each step |
| period_stb_o | output | 1 | One-cycle pulse at the start of each period |

## Verification
The bench changes N and H in the middle of a period. A sequencer that applied them at once would produce a staircase that is shortened or stretched, and the period strobe would fall at the wrong place. The bench checks the hold length of 1, where a counter that is off by one would skip or repeat codes, and a hold value of 0, which a design without the clamp would turn into a hold of 256 cycles. It also uses out-of-range step counts, which would otherwise give codes beyond 7 or an empty thermometer. Finally, it disables the block during a scan and enables it again, which would expose a design that resumes from a stale index or a stale hold count instead of restarting at code 0.

// File: rtl/dzw_pkg.sv
// Package dzw_pkg
// Shared helpers for the dead-zone width scan sequencer.
// Assumes the callers pass widths that can hold the clamp limits.
package dzw_pkg;

    // Clamp an integer into [lo, hi].
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Number of bits needed to hold values 0..v.
    function automatic int bits_for(input int v);
        int b;
        b = 1;
        while ((1 << b) <= v) b++;
        return b;
    endfunction

endpackage

// File: rtl/dzw_cfg_latch.sv
// Module dzw_cfg_latch
// Clamps the requested step count and hold length, and captures them
// only when load_i is high (the start of a period).
// Assumes STEP_MIN <= STEP_MAX < 2**NSEL_W.
module dzw_cfg_latch #(
    parameter int NSEL_W   = 4,
    parameter int HOLD_W   = 8,
    parameter int STEP_MIN = 4,
    parameter int STEP_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NSEL_W-1:0] n_raw_i,
    input  logic [HOLD_W-1:0] h_raw_i,
    output logic [NSEL_W-1:0] n_o,
    output logic [HOLD_W-1:0] h_o
);
    import dzw_pkg::*;

    localparam logic [NSEL_W-1:0] N_LO = NSEL_W'(STEP_MIN);
    localparam logic [NSEL_W-1:0] N_HI = NSEL_W'(STEP_MAX);
    localparam logic [HOLD_W-1:0] H_LO = HOLD_W'(1);

    logic [NSEL_W-1:0] n_cl;
    logic [HOLD_W-1:0] h_cl;

    // Clamp the raw requests into the legal ranges.
    always_comb begin
        n_cl = NSEL_W'(clamp_int(int'(n_raw_i), STEP_MIN, STEP_MAX));
        h_cl = (h_raw_i == '0) ? H_LO : h_raw_i;
    end

    // Shadow registers, updated only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_o <= N_LO;
            h_o <= H_LO;
        end else if (load_i) begin
            n_o <= n_cl;
            h_o <= h_cl;
        end
    end

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(n_o) && $stable(h_o)));
    assert_n_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (n_o >= N_LO) && (n_o <= N_HI));
    assert_h_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        h_o != '0);

endmodule

// File: rtl/dzw_hold_timer.sv
// Module dzw_hold_timer
// Counts slow-clock cycles inside one step and flags the last cycle of
// the step. Assumes hold_i is at least 1 and is stable within a step.
module dzw_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              run_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              expire_o
);
    logic [HOLD_W-1:0] hcnt_q;

    // Last cycle of the current step.
    always_comb expire_o = run_i && (hcnt_q == hold_i - HOLD_W'(1));

    // Cycle counter within a step; cleared at each step boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !run_i || expire_o) hcnt_q <= '0;
        else                                       hcnt_q <= hcnt_q + HOLD_W'(1);
    end

    assert_hcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (hcnt_q < hold_i));

endmodule

// File: rtl/dzw_step_ctr.sv
// Module dzw_step_ctr
// Holds the run state and the step index. It starts at index 0 when
// enabled, advances when the hold timer expires, and wraps after
// index n_i-1. Assumes n_i is at least 1 and at most 2**CODE_W.
module dzw_step_ctr #(
    parameter int CODE_W = 3,
    parameter int NSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              expire_i,
    input  logic [NSEL_W-1:0] n_i,
    output logic              run_o,
    output logic [CODE_W-1:0] idx_o,
    output logic              start_o,
    output logic              wrap_o
);
    logic last;

    // Period boundary decode.
    always_comb begin
        last    = ({{(NSEL_W){1'b0}}, idx_o} == {{(CODE_W){1'b0}}, n_i - NSEL_W'(1)});
        start_o = en_i && !run_o;
        wrap_o  = en_i && expire_i && last;
    end

    // Run flag and step index.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            run_o <= 1'b0;
            idx_o <= '0;
        end else if (start_o) begin
            run_o <= 1'b1;
            idx_o <= '0;
        end else if (expire_i) begin
            idx_o <= last ? '0 : idx_o + CODE_W'(1);
        end
    end

    assert_idx_below_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> ({{(NSEL_W){1'b0}}, idx_o} < {{(CODE_W){1'b0}}, n_i}));
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && en_i) |=> (idx_o == '0));

endmodule

// File: rtl/dzw_therm_enc.sv
// Module dzw_therm_enc
// Expands the active step count into a thermometer word. Bit i is set
// when i < n_i. The word is forced to zero when en_i is low.
module dzw_therm_enc #(
    parameter int NSEL_W = 4,
    parameter int WIDTH  = 8
) (
    input  logic              en_i,
    input  logic [NSEL_W-1:0] n_i,
    output logic [WIDTH-1:0]  therm_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One comparator per thermometer bit.
        assign therm_o[i] = en_i && (NSEL_W'(i) < n_i);
    end
endmodule

// File: rtl/dzw_scan_seq.sv
// Module dzw_scan_seq
// Top of the dead-zone width scan sequencer. It ties the configuration
// shadow, the hold timer, the step counter and the thermometer encoder
// together, and registers the step and period strobes.
// Assumes a single slow clock domain and a synchronous active-low reset.
module dzw_scan_seq #(
    parameter int CODE_W   = 3,
    parameter int NSEL_W   = 4,
    parameter int HOLD_W   = 8,
    parameter int STEP_MIN = 4,
    parameter int STEP_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic [NSEL_W-1:0] step_cnt_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic [CODE_W-1:0] phase_code_o,
    output logic [STEP_MAX-1:0] therm_o,
    output logic              code_valid_o,
    output logic              step_stb_o,
    output logic              period_stb_o
);
    logic [NSEL_W-1:0] n_act;
    logic [HOLD_W-1:0] h_act;
    logic              run, start, wrap, expire, load;
    logic [CODE_W-1:0] idx;

    // A period begins at the first enabled cycle or at a wrap.
    always_comb load = start || wrap;

    dzw_cfg_latch #(
        .NSEL_W(NSEL_W), .HOLD_W(HOLD_W),
        .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .n_raw_i(step_cnt_i), .h_raw_i(hold_len_i),
        .n_o(n_act), .h_o(h_act)
    );

    dzw_hold_timer #(.HOLD_W(HOLD_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr_i(!scan_en), .run_i(run),
        .hold_i(h_act), .expire_o(expire)
    );

    dzw_step_ctr #(.CODE_W(CODE_W), .NSEL_W(NSEL_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .en_i(scan_en), .expire_i(expire),
        .n_i(n_act), .run_o(run), .idx_o(idx),
        .start_o(start), .wrap_o(wrap)
    );

    dzw_therm_enc #(.NSEL_W(NSEL_W), .WIDTH(STEP_MAX)) therm_i (
        .en_i(run), .n_i(n_act), .therm_o(therm_o)
    );

    // Registered strobes, aligned with the new code.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            step_stb_o   <= 1'b0;
            period_stb_o <= 1'b0;
        end else begin
            step_stb_o   <= start || expire;
            period_stb_o <= load;
        end
    end

    // Code and valid come straight from the run state.
    always_comb begin
        code_valid_o = run;
        phase_code_o = run ? idx : '0;
    end

    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(scan_en) |-> (!code_valid_o && !step_stb_o && phase_code_o == '0));
    assert_period_in_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb_o |-> step_stb_o);
    assert_period_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb_o |-> (phase_code_o == '0));
    assert_start_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !code_valid_o) |=> (code_valid_o && period_stb_o));
    assert_therm_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> ($countones(therm_o) == int'(n_act)));

endmodule

// File: tb/dzw_scan_seq_tb.sv
`timescale 1ns/1ps
// Bench for dzw_scan_seq: a behavioural reference model compared on every clock.
module dzw_scan_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic [3:0] step_cnt = 4'd4;
    logic [7:0] hold_len = 8'd1;
    logic [2:0] code;
    logic [7:0] therm;
    logic       valid, stb, pstb;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    bit m_run = 0;
    int m_code = 0, m_left = 0, m_n = 4, m_h = 1;
    bit m_stb = 0, m_pstb = 0;

    always #2 clk = ~clk;

    dzw_scan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
        .step_cnt_i(step_cnt), .hold_len_i(hold_len),
        .phase_code_o(code), .therm_o(therm), .code_valid_o(valid),
        .step_stb_o(stb), .period_stb_o(pstb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic latch_cfg();
        m_n = (int'(step_cnt) < 4) ? 4 : (int'(step_cnt) > 8 ? 8 : int'(step_cnt)); // R8
        m_h = (hold_len == 0) ? 1 : int'(hold_len);                                 // R9
    endtask

    // Advance the model by one clock using the inputs the DUT sees.
    task automatic model_step();
        m_stb = 0; m_pstb = 0;
        if (!rst_n || !scan_en) begin
            m_run = 0; m_code = 0;
        end else if (!m_run) begin
            m_run = 1; latch_cfg(); m_code = 0; m_left = m_h; m_stb = 1; m_pstb = 1;
        end else begin
            m_left--;
            if (m_left == 0) begin
                m_stb = 1;
                if (m_code == m_n - 1) begin
                    m_code = 0; latch_cfg(); m_pstb = 1;
                end else m_code++;
                m_left = m_h;
            end
        end
    endtask

    task automatic compare_all();
        int exp_th;
        exp_th = m_run ? ((1 << m_n) - 1) : 0;
        chk(int'(code) == m_code, "R3 code", int'(code), m_code);
        chk(valid == m_run, "R6 valid", int'(valid), int'(m_run));
        chk(stb == m_stb, "R4 step strobe", int'(stb), int'(m_stb));
        chk(pstb == m_pstb, "R5 period strobe", int'(pstb), int'(m_pstb));
        chk(int'(therm) == exp_th, "R7 therm", int'(therm), exp_th);
    endtask

    // One cycle: inputs are already set at the negedge, so clock, model, then compare.
    task automatic cyc(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        @(negedge clk);
        cyc(3);
        // R1 reset state
        chk(code == 0 && therm == 0 && !valid && !stb && !pstb, "R1 reset", int'(valid), 0);
        rst_n = 1'b1;
        cyc(2);
        chk(!valid && therm == 0, "R1 idle after reset", int'(therm), 0);

        // R2/R3 N=4, H=1
        step_cnt = 4'd4; hold_len = 8'd1; scan_en = 1'b1;
        cyc(1);
        chk(valid && code == 0 && stb && pstb, "R2 start", int'(code), 0);
        cyc(11);

        // R10 mid-period change from N=4 H=2 to N=8 H=3
        scan_en = 1'b0; cyc(1);
        step_cnt = 4'd4; hold_len = 8'd2; scan_en = 1'b1; cyc(3);
        step_cnt = 4'd8; hold_len = 8'd3;
        cyc(5);
        chk(therm == 8'h0F, "R10 old N held", int'(therm), 15);
        cyc(40);
        chk(therm == 8'hFF, "R10 new N applied", int'(therm), 255);

        // R6 disable mid-scan then restart
        scan_en = 1'b0; cyc(1);
        chk(!valid && code == 0 && therm == 0 && !stb, "R6 off", int'(code), 0);
        cyc(3);
        step_cnt = 4'd5; hold_len = 8'd2; scan_en = 1'b1; cyc(1);
        chk(code == 0 && pstb, "R6 restart at 0", int'(code), 0);
        cyc(25);

        // R8 clamp low and high
        scan_en = 1'b0; cyc(1);
        step_cnt = 4'd2; hold_len = 8'd1; scan_en = 1'b1; cyc(1);
        chk(therm == 8'h0F, "R8 clamp low", int'(therm), 15);
        cyc(10);
        scan_en = 1'b0; cyc(1);
        step_cnt = 4'd15; scan_en = 1'b1; cyc(1);
        chk(therm == 8'hFF, "R8 clamp high", int'(therm), 255);
        cyc(20);

        // R9 hold of zero acts as one
        scan_en = 1'b0; cyc(1);
        step_cnt = 4'd6; hold_len = 8'd0; scan_en = 1'b1; cyc(2);
        chk(code == 1 && stb, "R9 zero hold", int'(code), 1);
        cyc(14);

        // longer hold run
        hold_len = 8'd7; cyc(120);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule